// File: doc/BRIEF.md
# Auto-Negotiation Arbitration and Resolution

This block makes the decisions in a 10/100 Ethernet auto-negotiation engine. Pulse generation, pulse timing and line sensing sit outside it. It receives link code words that have already been decoded from the partner's pulse bursts. It also receives two flags that report a 10 Mb/s or 100 Mb/s idle pattern on the line. Inside, it checks that the partner keeps sending the same word and latches that word as the partner's abilities. It then waits for the acknowledge phase and picks the best technology that both ends support. It reports the chosen speed and duplex, a completion flag and a failure flag.

Code words arrive on a valid/ready stream. A word transfers only on a cycle where both `cw_valid` and `cw_ready` are high. `cw_ready` is high while negotiation is running and low once a link has been resolved. While `cw_ready` is low, a sender must hold its word, and the held word has no effect on the block. The idle flags, the restart request, the link-health input and the repeater flag are plain level signals and are sampled every cycle.

Top module: `anr_arbiter`

## Requirements
- R1: After reset, `an_done`, `an_fail`, `link_speed100`, `link_full` and `partner_word` are all 0, and `cw_ready` is 1.
- R2: In the ability phase, `partner_word` takes the value of the third of three consecutive accepted words that are identical in every bit except bit 14 (the acknowledge bit). After only two such words, `partner_word` is unchanged.
- R3: During the ability phase, an accepted word that differs (ignoring bit 14) from the previous accepted word restarts the match count at one. So after A, A, B, B, B the latched word is B, and it is latched on the fifth word.
- R4: After the latch, the block needs three consecutive accepted words that are identical and have bit 14 set before it resolves. An accepted word with bit 14 clear resets this count to zero.
- R5: Ability bits 5, 6, 7 and 8 mean 10 Mb/s half, 10 Mb/s full, 100 Mb/s half and 100 Mb/s full. Resolution uses bits 8:5 that are set in both `local_ability` and the latched partner word. It picks, in falling priority, 100 full, 100 half, 10 full, 10 half. On completion, `an_done`=1, `link_speed100`=1 for 100 Mb/s and `link_full`=1 for full duplex.
- R6: When `repeater_mode` is 1 at resolution, the full-duplex abilities are excluded, so `link_full` is never 1.
- R7: If no ability is common at resolution, `an_fail` is set, `an_done` stays 0 and the block returns to the ability phase with its counts cleared (`cw_ready`=1).
- R8: While negotiating, `idle100_det`=1 completes at 100 Mb/s half duplex, and `idle10_det`=1 completes at 10 Mb/s half duplex. When both are high, 100 Mb/s wins. An idle flag takes precedence over a word accepted in the same cycle.
- R9: If negotiation has not completed within `TIMEOUT_CYC` cycles of its start, `an_fail` is set and negotiation restarts from the ability phase.
- R10: `restart_req`=1 clears `an_done`, `link_speed100` and `link_full` on the next edge and restarts the ability phase with cleared counts. `an_fail` is left unchanged.
- R11: While a link is resolved, `link_ok`=0 clears `an_done` and restarts negotiation.
- R12: `cw_ready` is 0 while `an_done` is 1. A word offered then is not consumed and leaves `partner_word`, `an_done`, speed and duplex unchanged.
- R13: `an_fail` returns to 0 on the next successful completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on start) |
| cw_valid | input | 1 | Decoded code word is offered |
| cw_ready | output | 1 | Block accepts a code word this cycle |
| cw_data | input | 16 | Decoded link code word |
| idle10_det | input | 1 | 10 Mb/s idle pattern seen on the line |
| idle100_det | input | 1 | 100 Mb/s idle pattern seen on the line |
| local_ability | input | 16 | Local advertised word; bits 8:5 used |
| repeater_mode | input | 1 | Forbid full duplex |
| restart_req | input | 1 | Restart negotiation |
| link_ok | input | 1 | Link health; 0 means link lost |
| an_done | output | 1 | Negotiation complete |
| an_fail | output | 1 | Last attempt failed |
| link_speed100 | output | 1 | Resolved speed is 100 Mb/s |
| link_full | output | 1 | Resolved duplex is full |
| partner_word | output | 16 | Latched partner code word |

## Verification
The assertions check properties that must hold on every cycle. These are: the stream stalls while a link is up, and the latched word stays frozen then. Done and fail are never high together. A restart always drops completion. A repeater or idle-pattern resolution never yields full duplex. The match counters and the timeout timer stay inside their bounds. Several behaviours only show up in the bench's sequences and their expected results: the exact word on which the latch and the completion happen, the match count restarting after a mismatch or a cleared acknowledge bit, the choice of the priority winner across random ability pairs, the timeout moment, and the clearing of the fail flag.

// File: rtl/anr_pkg.sv
package anr_pkg;
  localparam int CW_W     = 16;
  localparam int ACK_POS  = 14;
  localparam int TECH_LSB = 5;
  localparam int N_TECH   = 4;

  typedef enum logic [1:0] {
    AN_ABIL = 2'd0,
    AN_ACK  = 2'd1,
    AN_LINK = 2'd2
  } an_state_e;
endpackage

// File: rtl/anr_match_track.sv
module anr_match_track #(
  parameter int W    = 16,
  parameter int NEED = 3,
  parameter logic [W-1:0] CMP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic         qual,
  input  logic [W-1:0] word,
  output logic         hit
);
  localparam int CW = $clog2(NEED + 1);

  logic [W-1:0]  last_q;
  logic          have_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          same;

  assign same = have_q && ((word & CMP_MASK) == (last_q & CMP_MASK));

  always_comb begin
    if (same) cnt_nx = (cnt_q == CW'(NEED)) ? cnt_q : cnt_q + 1'b1;
    else      cnt_nx = CW'(1);
  end

  assign hit = push && qual && (cnt_nx == CW'(NEED));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      last_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (push) begin
      if (!qual) begin
        have_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        last_q <= word;
        have_q <= 1'b1;
        cnt_q  <= cnt_nx;
      end
    end
  end

  AST_MATCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NEED)); // R2
  AST_UNQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !qual && !clear) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/anr_prio_resolve.sv
module anr_prio_resolve #(
  parameter int N = 4
) (
  input  logic [N-1:0] local_tech,
  input  logic [N-1:0] peer_tech,
  input  logic         no_full,
  output logic         found,
  output logic         sel_speed100,
  output logic         sel_full
);
  logic [N-1:0] common;
  logic [N-1:0] win;
  logic [N-1:0] full_m;
  logic [N-1:0] fast_m;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_tech
      assign full_m[i] = (i % 2) == 1;
      assign fast_m[i] = (i / 2) >= 1;
      assign common[i] = local_tech[i] && peer_tech[i] && !(no_full && full_m[i]);
      if (i == N - 1) begin : g_top
        assign win[i] = common[i];
      end else begin : g_low
        assign win[i] = common[i] && !(|common[N-1:i+1]);
      end
    end
  endgenerate

  assign found        = |common;
  assign sel_speed100 = |(win & fast_m);
  assign sel_full     = |(win & full_m);
endmodule

// File: rtl/anr_fail_timer.sv
module anr_fail_timer #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt_q;

  assign expire = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (run)        cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TW'(LIMIT)); // R9
endmodule

// File: rtl/anr_arbiter.sv
module anr_arbiter
  import anr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 512,
  parameter int MATCH_NEED  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cw_valid,
  output logic            cw_ready,
  input  logic [CW_W-1:0] cw_data,
  input  logic            idle10_det,
  input  logic            idle100_det,
  input  logic [CW_W-1:0] local_ability,
  input  logic            repeater_mode,
  input  logic            restart_req,
  input  logic            link_ok,
  output logic            an_done,
  output logic            an_fail,
  output logic            link_speed100,
  output logic            link_full,
  output logic [CW_W-1:0] partner_word
);
  localparam logic [CW_W-1:0] NO_ACK = ~(CW_W'(1) << ACK_POS);

  an_state_e       state_q;
  logic            done_q, fail_q, spd_q, fdx_q;
  logic [CW_W-1:0] pword_q;

  logic negot, ev_restart, ev_pd, ev_tmo, quiet, accept;
  logic push_a, push_b, clr_a, clr_b, hit_a, hit_b, tmr_clr;
  logic res_found, res_spd, res_fdx;

  assign negot      = (state_q != AN_LINK);
  assign cw_ready   = negot;
  assign ev_restart = restart_req || (!negot && !link_ok);
  assign ev_pd      = negot && (idle10_det || idle100_det);
  assign quiet      = !ev_restart && !ev_pd && !ev_tmo;
  assign accept     = cw_valid && cw_ready;
  assign push_a     = accept && (state_q == AN_ABIL) && quiet;
  assign push_b     = accept && (state_q == AN_ACK) && quiet;
  assign clr_a      = (state_q != AN_ABIL) || !quiet || hit_a;
  assign clr_b      = (state_q != AN_ACK) || !quiet || hit_b;
  assign tmr_clr    = !negot || ev_restart || ev_pd || ev_tmo || hit_b;

  anr_match_track #(.W(CW_W), .NEED(MATCH_NEED), .CMP_MASK(NO_ACK)) i_abil_track (
    .clk(clk), .rst_n(rst_n), .clear(clr_a), .push(push_a),
    .qual(1'b1), .word(cw_data), .hit(hit_a));

  anr_match_track #(.W(CW_W), .NEED(MATCH_NEED), .CMP_MASK('1)) i_ack_track (
    .clk(clk), .rst_n(rst_n), .clear(clr_b), .push(push_b),
    .qual(cw_data[ACK_POS]), .word(cw_data), .hit(hit_b));

  anr_fail_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .run(negot), .expire(ev_tmo));

  anr_prio_resolve #(.N(N_TECH)) i_resolve (
    .local_tech(local_ability[TECH_LSB +: N_TECH]),
    .peer_tech(pword_q[TECH_LSB +: N_TECH]),
    .no_full(repeater_mode),
    .found(res_found), .sel_speed100(res_spd), .sel_full(res_fdx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= AN_ABIL;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      spd_q   <= 1'b0;
      fdx_q   <= 1'b0;
      pword_q <= '0;
    end else if (ev_restart) begin
      state_q <= AN_ABIL;
      done_q  <= 1'b0;
      spd_q   <= 1'b0;
      fdx_q   <= 1'b0;
    end else if (ev_pd) begin
      state_q <= AN_LINK;
      done_q  <= 1'b1;
      fail_q  <= 1'b0;
      spd_q   <= idle100_det;
      fdx_q   <= 1'b0;
    end else if (ev_tmo) begin
      state_q <= AN_ABIL;
      fail_q  <= 1'b1;
    end else if (hit_a) begin
      pword_q <= cw_data;
      state_q <= AN_ACK;
    end else if (hit_b) begin
      if (res_found) begin
        state_q <= AN_LINK;
        done_q  <= 1'b1;
        fail_q  <= 1'b0;
        spd_q   <= res_spd;
        fdx_q   <= res_fdx;
      end else begin
        state_q <= AN_ABIL;
        fail_q  <= 1'b1;
      end
    end
  end

  assign an_done       = done_q;
  assign an_fail       = fail_q;
  assign link_speed100 = spd_q;
  assign link_full     = fdx_q;
  assign partner_word  = pword_q;

  AST_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |-> !cw_ready); // R12
  AST_PWORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && $past(an_done)) |-> $stable(partner_word)); // R12
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(an_done && an_fail)); // R7
  AST_RPTR_NO_FDX: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(an_done) && $past(repeater_mode)) |-> !link_full); // R6
  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !an_done); // R10
  AST_PD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(an_done) && $past(idle10_det || idle100_det)) |-> !link_full); // R8
endmodule

// File: tb/test_anr_arbiter.sv
module test_anr_arbiter;
  localparam int T_TMO = 300;
  localparam logic [15:0] ACK = 16'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_valid = 1'b0;
  logic cw_ready;
  logic [15:0] cw_data = '0;
  logic idle10_det = 1'b0, idle100_det = 1'b0;
  logic [15:0] local_ability = 16'h01E0;
  logic repeater_mode = 1'b0, restart_req = 1'b0, link_ok = 1'b1;
  logic an_done, an_fail, link_speed100, link_full;
  logic [15:0] partner_word;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  anr_arbiter #(.TIMEOUT_CYC(T_TMO), .MATCH_NEED(3)) i_anr_arbiter (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_data(cw_data), .idle10_det(idle10_det), .idle100_det(idle100_det),
    .local_ability(local_ability), .repeater_mode(repeater_mode),
    .restart_req(restart_req), .link_ok(link_ok), .an_done(an_done),
    .an_fail(an_fail), .link_speed100(link_speed100), .link_full(link_full),
    .partner_word(partner_word));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    cw_valid = 1'b1; cw_data = w;
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  task automatic restart();
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
  endtask

  // expected result: {found, speed100, full}
  function automatic logic [2:0] model(input logic [15:0] loc, input logic [15:0] par,
                                       input logic rpt);
    logic [3:0] c;
    c = loc[8:5] & par[8:5];
    if (rpt) c = c & 4'b0101;
    if (c[3]) return 3'b111;
    if (c[2]) return 3'b110;
    if (c[1]) return 3'b101;
    if (c[0]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [15:0] wa, wb, wr, lr;
    logic [2:0] ex;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 done", {15'd0, an_done}, 16'd0);
    chk("R1 fail", {15'd0, an_fail}, 16'd0);
    chk("R1 speed/full", {14'd0, link_speed100, link_full}, 16'd0);
    chk("R1 partner", partner_word, 16'd0);
    chk("R1 ready", {15'd0, cw_ready}, 16'd1);

    // R2 latch on third word, ack bit ignored in compare
    wa = 16'h0101;
    send(wa); send(wa | ACK);
    chk("R2 no latch after two", partner_word, 16'd0);
    send(wa);
    chk("R2 latch on third", partner_word, wa);

    // R4 ack phase: cleared ack bit resets count
    send(wa | ACK); send(wa | ACK); send(wa);
    send(wa | ACK); send(wa | ACK);
    chk("R4 not done yet", {15'd0, an_done}, 16'd0);
    send(wa | ACK);
    chk("R4 done", {15'd0, an_done}, 16'd1);
    chk("R5 100 full", {14'd0, link_speed100, link_full}, 16'd3);

    // R12 stall while linked
    chk("R12 ready low", {15'd0, cw_ready}, 16'd0);
    send(16'h0021); send(16'h0021); send(16'h0021);
    chk("R12 word ignored", partner_word, wa);
    chk("R12 still done", {14'd0, an_done, link_full}, 16'd3);

    // R11 link loss
    link_ok = 1'b0; tick(1); link_ok = 1'b1;
    chk("R11 done cleared", {15'd0, an_done}, 16'd0);
    chk("R11 ready again", {15'd0, cw_ready}, 16'd1);

    // R3 mismatch restarts count
    wb = 16'h0041;
    send(16'h0081); send(16'h0081); send(wb); send(wb);
    chk("R3 no latch yet", partner_word, wa);
    send(wb);
    chk("R3 latch B", partner_word, wb);
    send(wb | ACK); send(wb | ACK); send(wb | ACK);
    chk("R5 10 full", {13'd0, an_done, link_speed100, link_full}, 16'd5);

    // R6 repeater excludes full
    restart();
    repeater_mode = 1'b1;
    wa = 16'h0121;
    send(wa); send(wa); send(wa);
    send(wa | ACK); send(wa | ACK); send(wa | ACK);
    chk("R6 repeater half", {13'd0, an_done, link_speed100, link_full}, 16'd4);
    repeater_mode = 1'b0;

    // R7 no common mode
    restart();
    local_ability = 16'h0060;
    wa = 16'h0181;
    send(wa); send(wa); send(wa);
    send(wa | ACK); send(wa | ACK); send(wa | ACK);
    chk("R7 fail set", {14'd0, an_fail, an_done}, 16'd2);
    chk("R7 back to ability", {15'd0, cw_ready}, 16'd1);
    // R10 restart leaves fail
    restart();
    chk("R10 fail kept", {15'd0, an_fail}, 16'd1);
    local_ability = 16'h01E0;

    // R8 parallel detect beats same-cycle word; R13 clears fail
    idle100_det = 1'b1; cw_valid = 1'b1; cw_data = 16'h0021;
    tick(1);
    idle100_det = 1'b0; cw_valid = 1'b0;
    chk("R8 100 half", {13'd0, an_done, link_speed100, link_full}, 16'd6);
    chk("R13 fail cleared", {15'd0, an_fail}, 16'd0);
    restart();
    chk("R10 done cleared", {14'd0, an_done, link_speed100}, 16'd0);
    idle10_det = 1'b1; tick(1); idle10_det = 1'b0;
    chk("R8 10 half", {13'd0, an_done, link_speed100, link_full}, 16'd4);
    restart();
    idle10_det = 1'b1; idle100_det = 1'b1; tick(1);
    idle10_det = 1'b0; idle100_det = 1'b0;
    chk("R8 both -> 100", {13'd0, an_done, link_speed100, link_full}, 16'd6);

    // R9 timeout
    restart();
    tick(T_TMO - 3);
    chk("R9 no fail before timeout", {15'd0, an_fail}, 16'd0);
    tick(5);
    chk("R9 fail after timeout", {14'd0, an_fail, an_done}, 16'd2);

    // R5 random ability pairs
    for (int it = 0; it < 40; it++) begin
      restart();
      lr = 16'($urandom) & 16'h01E0;
      wr = 16'($urandom) & ~ACK;
      repeater_mode = 1'($urandom);
      local_ability = lr;
      ex = model(lr, wr, repeater_mode);
      send(wr); send(wr); send(wr);
      send(wr | ACK); send(wr | ACK); send(wr | ACK);
      if (ex[2]) begin
        chk("R5 random resolve", {13'd0, an_done, link_speed100, link_full},
            {13'd0, 1'b1, ex[1], ex[0]});
        chk("R13 random fail clear", {15'd0, an_fail}, 16'd0);
      end else begin
        chk("R7 random no common", {14'd0, an_fail, an_done}, 16'd2);
      end
    end
    repeater_mode = 1'b0;
    summary();
  end
endmodule